// File: doc/BRIEF.md
# Pulse Sequence Transmitter with Looping

This block plays a stored list of timed levels onto one output pin. Each entry in an external synchronous memory holds one pin level and a duration in clock cycles. A zero duration ends the sequence. A start pulse makes the block fetch entries from its current read pointer and drive them in turn. At the end marker the block either returns to idle or, in continuous mode, starts again from entry 0. A pass counter with a programmable limit can end a continuous run after a set number of passes.

An entry-count threshold gives one event pulse when the sequence goes beyond a programmed number of entries. A stop pulse abandons a transmission at once. If the read pointer runs off the end of the memory without meeting a marker, the block either wraps to address 0 or stops and sets a sticky empty error. When idle, the pin shows a programmable level, and its output enable follows a programmable bit.

Top module: `pulse_seq_tx`

## Requirements
- R1: After reset the state is idle (state code 0), the read pointer, the pass count, the empty error, the memory read strobe and all three event outputs are 0.
- R2: While idle (state 0), pin_o equals idle_level_i and pin_oe_o equals idle_oe_i, combinationally.
- R3: A start pulse sampled while idle begins a fetch from the current read pointer. State codes are: fetch 1 (mem_rd_o high, address = pointer, data returned the next cycle), decode 2, send 3. An entry carries its level in bit 15 and its duration D in bits 14:0. Its level reaches the pin when it is decoded and stays for D+2 cycles: D send cycles plus the fetch and decode of the next entry. During the first two cycles after start the pin shows the idle level, and pin_oe_o is 1 in every non-idle state.
- R4: In one-shot mode, a decoded entry of duration 0 returns the block to idle. In that same cycle end_evt_o pulses for one cycle, 2+Σ(D+2) cycles after the edge that samples start. The read pointer is left at the index of the marker.
- R5: A pulse on rd_ptr_clr_i sets the read pointer to 0.
- R6: In continuous mode a decoded end marker restarts fetching at entry 0. It raises no end event unless the pass limit is reached.
- R7: With counting enabled in continuous mode, each end marker adds 1 to loop_count_o. When the new count equals a non-zero loop_limit_i, loop_evt_o and end_evt_o pulse together and the block goes idle. A limit of 0 never ends the run. loop_clr_i zeroes the count.
- R8: thr_evt_o pulses once per start, in the first send cycle of entry number entry_limit_i+1.
- R9: If the pointer passes the last memory address (MEM_DEPTH-1) while sending, the block goes to address 0 when wrap_en_i is 1. When wrap_en_i is 0 it goes idle, sets empty_err_o and raises no end event. The error holds until the next start.
- R10: A stop pulse in any non-idle state returns the block to idle on the next edge, with no end event. A stop that arrives together with a start while idle keeps the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| cont_mode_i | input | 1 | Continuous (repeat) mode |
| wrap_en_i | input | 1 | Wrap pointer past last address |
| loop_cnt_en_i | input | 1 | Enable pass counting |
| loop_limit_i | input | LOOP_W | Pass limit (0 = none) |
| loop_clr_i | input | 1 | Clear pass counter |
| entry_limit_i | input | LIM_W | Entry threshold |
| rd_ptr_clr_i | input | 1 | Clear read pointer |
| idle_level_i | input | 1 | Pin level while idle |
| idle_oe_i | input | 1 | Pin enable while idle |
| mem_addr_o | output | ADDR_W | Entry memory address |
| mem_rd_o | output | 1 | Entry memory read strobe |
| mem_rdata_i | input | ENTRY_W | Entry memory data (one cycle after strobe) |
| pin_o | output | 1 | Output pin level |
| pin_oe_o | output | 1 | Output pin enable |
| state_o | output | 3 | State code |
| rd_ptr_o | output | ADDR_W | Read pointer |
| loop_count_o | output | LOOP_W | Pass count |
| empty_err_o | output | 1 | Memory exhausted without marker |
| end_evt_o | output | 1 | Transmission end pulse |
| thr_evt_o | output | 1 | Entry threshold pulse |
| loop_evt_o | output | 1 | Pass limit pulse |

## Verification
The bench times the end pulse against the 2+Σ(D+2) formula. A design that drops the fetch gap or counts the marker as an entry ends early or late. It also samples the pin in the cycles on each side of every level change, which exposes a level latched one entry off. In the continuous runs the bench checks that the limit ends the run on exactly the third marker and that a zero limit never ends it. A comparison that is off by one, or a count taken at restart, stops a pass too soon or too late. The threshold run checks that the pulse marks entry limit+1 and fires only once. The exhaustion runs check that the error comes without an end pulse and that wrapping keeps the block busy. The stop runs check that a stop beats a simultaneous start and that a stop in mid-run gives no end pulse.

// File: rtl/pstx_pkg.sv
`timescale 1ns/1ps
package pstx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_FETCH  = 3'd1,
      ST_DECODE = 3'd2,
      ST_SEND   = 3'd3
   } pstx_state_e;
endpackage

// File: rtl/pstx_loop_ctr.sv
`timescale 1ns/1ps
module pstx_loop_ctr #(
   parameter int LOOP_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              pass_i,
   input  logic              en_i,
   input  logic [LOOP_W-1:0] limit_i,
   output logic [LOOP_W-1:0] count_o,
   output logic              hit_o
);
   localparam int EXT_W = LOOP_W + 1;

   logic [LOOP_W-1:0] cnt_q;
   logic [EXT_W-1:0]  next_ext;

   assign next_ext = {1'b0, cnt_q} + EXT_W'(1);
   assign hit_o    = en_i && pass_i && (limit_i != '0) && (next_ext == {1'b0, limit_i});
   assign count_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr_i)         cnt_q <= '0;
      else if (pass_i && en_i) cnt_q <= cnt_q + 1'b1;
   end

   AST_LOOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      en_i && pass_i && !clr_i |=> count_o == $past(count_o) + 1'b1); // R7
   AST_LOOP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> count_o == '0); // R7
endmodule

// File: rtl/pstx_thresh.sv
`timescale 1ns/1ps
module pstx_thresh #(
   parameter int LIM_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             accept_i,
   input  logic [LIM_W-1:0] limit_i,
   output logic             evt_o
);
   localparam int CW = LIM_W + 1;

   logic [CW-1:0] seen_q;

   assign evt_o = accept_i && (seen_q == {1'b0, limit_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q <= '0;
      else if (restart_i) seen_q <= '0;
      else if (accept_i && (seen_q <= {1'b0, limit_i}))
         seen_q <= seen_q + 1'b1;
   end

   AST_THR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> (!evt_o || $past(restart_i))); // R8
endmodule

// File: rtl/pstx_drive.sv
`timescale 1ns/1ps
module pstx_drive (
   input  logic active_i,
   input  logic level_i,
   input  logic idle_level_i,
   input  logic idle_oe_i,
   output logic pin_o,
   output logic pin_oe_o
);
   always_comb begin
      if (active_i) begin
         pin_o    = level_i;
         pin_oe_o = 1'b1;
      end else begin
         pin_o    = idle_level_i;
         pin_oe_o = idle_oe_i;
      end
   end
endmodule

// File: rtl/pulse_seq_tx.sv
`timescale 1ns/1ps
module pulse_seq_tx
   import pstx_pkg::*;
#(
   parameter int ENTRY_W   = 16,
   parameter int ADDR_W    = 9,
   parameter int MEM_DEPTH = 128,
   parameter int LOOP_W    = 10,
   parameter int LIM_W     = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               cont_mode_i,
   input  logic               wrap_en_i,
   input  logic               loop_cnt_en_i,
   input  logic [LOOP_W-1:0]  loop_limit_i,
   input  logic               loop_clr_i,
   input  logic [LIM_W-1:0]   entry_limit_i,
   input  logic               rd_ptr_clr_i,
   input  logic               idle_level_i,
   input  logic               idle_oe_i,
   output logic [ADDR_W-1:0]  mem_addr_o,
   output logic               mem_rd_o,
   input  logic [ENTRY_W-1:0] mem_rdata_i,
   output logic               pin_o,
   output logic               pin_oe_o,
   output logic [2:0]         state_o,
   output logic [ADDR_W-1:0]  rd_ptr_o,
   output logic [LOOP_W-1:0]  loop_count_o,
   output logic               empty_err_o,
   output logic               end_evt_o,
   output logic               thr_evt_o,
   output logic               loop_evt_o
);
   localparam int DUR_W = ENTRY_W - 1;
   localparam logic [ADDR_W-1:0] LAST_PTR = ADDR_W'(MEM_DEPTH);

   if (ENTRY_W < 2) begin : g_bad_entry
      $error("ENTRY_W must be at least 2");
   end
   if (MEM_DEPTH < 1 || MEM_DEPTH >= (1 << ADDR_W)) begin : g_bad_depth
      $error("MEM_DEPTH must fit below 2**ADDR_W");
   end

   pstx_state_e       state_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              level_q;
   logic [DUR_W-1:0]  left_q;
   logic              err_q, end_q, thr_q, loop_q;

   logic              ent_level;
   logic [DUR_W-1:0]  ent_dur;
   logic              go, accept, marker, pass_done, loop_hit, thr_evt;

   assign ent_level = mem_rdata_i[ENTRY_W-1];
   assign ent_dur   = mem_rdata_i[DUR_W-1:0];
   assign go        = (state_q == ST_IDLE) && start_i && !stop_i;
   assign accept    = (state_q == ST_DECODE) && (ent_dur != '0) && !stop_i;
   assign marker    = (state_q == ST_DECODE) && (ent_dur == '0) && !stop_i;
   assign pass_done = marker && cont_mode_i;

   pstx_loop_ctr #(.LOOP_W(LOOP_W)) loop_ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (loop_clr_i),
      .pass_i  (pass_done),
      .en_i    (loop_cnt_en_i),
      .limit_i (loop_limit_i),
      .count_o (loop_count_o),
      .hit_o   (loop_hit)
   );

   pstx_thresh #(.LIM_W(LIM_W)) thresh_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (go),
      .accept_i  (accept),
      .limit_i   (entry_limit_i),
      .evt_o     (thr_evt)
   );

   pstx_drive drive_i (
      .active_i     (state_q != ST_IDLE),
      .level_i      (level_q),
      .idle_level_i (idle_level_i),
      .idle_oe_i    (idle_oe_i),
      .pin_o        (pin_o),
      .pin_oe_o     (pin_oe_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         level_q <= 1'b0;
         left_q  <= '0;
         err_q   <= 1'b0;
         end_q   <= 1'b0;
         thr_q   <= 1'b0;
         loop_q  <= 1'b0;
      end else begin
         end_q  <= 1'b0;
         loop_q <= 1'b0;
         thr_q  <= thr_evt;
         unique case (state_q)
            ST_IDLE: begin
               if (go) begin
                  state_q <= ST_FETCH;
                  level_q <= idle_level_i;
                  err_q   <= 1'b0;
               end
            end
            ST_FETCH: state_q <= ST_DECODE;
            ST_DECODE: begin
               if (accept) begin
                  level_q <= ent_level;
                  left_q  <= ent_dur;
                  ptr_q   <= ptr_q + 1'b1;
                  state_q <= ST_SEND;
               end else if (cont_mode_i && !loop_hit) begin
                  ptr_q   <= '0;
                  state_q <= ST_FETCH;
               end else begin
                  state_q <= ST_IDLE;
                  end_q   <= 1'b1;
                  loop_q  <= loop_hit;
               end
            end
            ST_SEND: begin
               if (left_q == DUR_W'(1)) begin
                  if (ptr_q != LAST_PTR) begin
                     state_q <= ST_FETCH;
                  end else if (wrap_en_i) begin
                     ptr_q   <= '0;
                     state_q <= ST_FETCH;
                  end else begin
                     err_q   <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (stop_i && state_q != ST_IDLE) begin
            state_q <= ST_IDLE;
            end_q   <= 1'b0;
            loop_q  <= 1'b0;
         end
         if (rd_ptr_clr_i) ptr_q <= '0;
      end
   end

   assign mem_rd_o    = (state_q == ST_FETCH);
   assign mem_addr_o  = ptr_q;
   assign state_o     = state_q;
   assign rd_ptr_o    = ptr_q;
   assign empty_err_o = err_q;
   assign end_evt_o   = end_q;
   assign thr_evt_o   = thr_q;
   assign loop_evt_o  = loop_q;

   AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_IDLE && start_i && !stop_i |=> state_o == 3'd1); // R3
   AST_ACTIVE_OE: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 3'd0 |-> pin_oe_o); // R3
   AST_IDLE_OE: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd0 |-> pin_oe_o == idle_oe_i); // R2
   AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd2 && mem_rdata_i[DUR_W-1:0] == '0 && !stop_i && cont_mode_i && !loop_hit
      |=> state_o == 3'd1 && rd_ptr_o == '0); // R6
   AST_LOOP_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
      loop_evt_o |-> end_evt_o && state_o == 3'd0); // R7
   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr_o <= LAST_PTR); // R9
   AST_ERR_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(empty_err_o) |-> !end_evt_o && state_o == 3'd0); // R9
   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 3'd0 && stop_i |=> state_o == 3'd0 && !end_evt_o); // R10
endmodule

// File: tb/pulse_seq_tx_tb_top.sv
`timescale 1ns/1ps
module pulse_seq_tx_tb_top;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 0, stop_i = 0, cont_mode_i = 0, wrap_en_i = 0;
   logic        loop_cnt_en_i = 0, loop_clr_i = 0, rd_ptr_clr_i = 0;
   logic        idle_level_i = 0, idle_oe_i = 0;
   logic [9:0]  loop_limit_i = '0;
   logic [8:0]  entry_limit_i = 9'd128;
   logic [8:0]  mem_addr;
   logic        mem_rd;
   logic [15:0] mem_rdata = '0;
   logic        pin_o, pin_oe_o, empty_err_o, end_evt_o, thr_evt_o, loop_evt_o;
   logic [2:0]  state_o;
   logic [8:0]  rd_ptr_o;
   logic [9:0]  loop_count_o;

   logic [15:0] tb_mem [0:DEPTH-1];
   int checks = 0;
   int fails = 0;

   logic       pin_a [0:63];
   logic       oe_a  [0:63];
   logic [2:0] st_a  [0:63];
   logic       end_a [0:63];
   logic       thr_a [0:63];
   logic       loop_a[0:63];
   logic       err_a [0:63];

   always #10 clk = ~clk;

   always_ff @(posedge clk) begin
      if (mem_rd) mem_rdata <= tb_mem[mem_addr[2:0]];
   end

   pulse_seq_tx #(.MEM_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .cont_mode_i(cont_mode_i), .wrap_en_i(wrap_en_i), .loop_cnt_en_i(loop_cnt_en_i),
      .loop_limit_i(loop_limit_i), .loop_clr_i(loop_clr_i), .entry_limit_i(entry_limit_i),
      .rd_ptr_clr_i(rd_ptr_clr_i), .idle_level_i(idle_level_i), .idle_oe_i(idle_oe_i),
      .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
      .pin_o(pin_o), .pin_oe_o(pin_oe_o), .state_o(state_o), .rd_ptr_o(rd_ptr_o),
      .loop_count_o(loop_count_o), .empty_err_o(empty_err_o), .end_evt_o(end_evt_o),
      .thr_evt_o(thr_evt_o), .loop_evt_o(loop_evt_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put(input int idx, input logic lvl, input int dur);
      tb_mem[idx] = {lvl, 15'(dur)};
   endtask

   task automatic clr_ptr();
      @(negedge clk) rd_ptr_clr_i = 1;
      @(negedge clk) rd_ptr_clr_i = 0;
   endtask

   task automatic clr_loop();
      @(negedge clk) loop_clr_i = 1;
      @(negedge clk) loop_clr_i = 0;
   endtask

   // start sampled at edge E0; index i of the capture is the negedge after edge Ei
   task automatic start_capture(input int n);
      @(negedge clk) start_i = 1;
      @(negedge clk) start_i = 0;
      for (int i = 0; i < n; i++) begin
         if (i > 0) @(negedge clk);
         pin_a[i] = pin_o;  oe_a[i] = pin_oe_o; st_a[i] = state_o;
         end_a[i] = end_evt_o; thr_a[i] = thr_evt_o; loop_a[i] = loop_evt_o;
         err_a[i] = empty_err_o;
      end
   endtask

   function automatic int first_end(input int n);
      for (int i = 0; i < n; i++) if (end_a[i]) return i;
      return -1;
   endfunction

   function automatic int count_end(input int n);
      int c = 0;
      for (int i = 0; i < n; i++) if (end_a[i]) c++;
      return c;
   endfunction

   task automatic t_reset();
      check("R1 state", 32'(state_o), 0);
      check("R1 rd_ptr", 32'(rd_ptr_o), 0);
      check("R1 loop_count", 32'(loop_count_o), 0);
      check("R1 err", 32'(empty_err_o), 0);
      check("R1 events", 32'({end_evt_o, thr_evt_o, loop_evt_o, mem_rd}), 0);
   endtask

   task automatic t_idle_drive();
      @(negedge clk) begin idle_level_i = 1; idle_oe_i = 1; end
      #1;
      check("R2 idle pin", 32'(pin_o), 1);
      check("R2 idle oe", 32'(pin_oe_o), 1);
      idle_level_i = 0; idle_oe_i = 0;
      #1;
      check("R2 idle oe off", 32'(pin_oe_o), 0);
      check("R2 idle pin low", 32'(pin_o), 0);
   endtask

   task automatic t_one_shot();
      idle_level_i = 0; idle_oe_i = 1; cont_mode_i = 0;
      put(0, 1, 5); put(1, 0, 3); put(2, 1, 2); put(3, 0, 0);
      clr_ptr();
      start_capture(24);
      check("R3 pre pin", 32'({pin_a[0], oe_a[0]}), 32'b01);
      check("R3 pre pin 1", 32'({pin_a[1], oe_a[1]}), 32'b01);
      check("R3 entry0 start", 32'(pin_a[2]), 1);
      check("R3 entry0 hold", 32'(pin_a[8]), 1);
      check("R3 entry1 start", 32'(pin_a[9]), 0);
      check("R3 entry1 hold", 32'(pin_a[13]), 0);
      check("R3 entry2 start", 32'(pin_a[14]), 1);
      check("R3 entry2 hold", 32'({pin_a[17], oe_a[17]}), 32'b11);
      check("R4 end time", 32'(first_end(24)), 18);
      check("R4 end once", 32'(count_end(24)), 1);
      check("R4 idle at end", 32'(st_a[18]), 0);
      check("R2 idle after", 32'({pin_a[18], oe_a[18]}), 32'b01);
      check("R4 ptr at marker", 32'(rd_ptr_o), 3);
      clr_ptr();
      check("R5 ptr cleared", 32'(rd_ptr_o), 0);
   endtask

   task automatic t_cont_loop();
      put(0, 1, 2); put(1, 0, 2); put(2, 0, 0);
      cont_mode_i = 1; loop_cnt_en_i = 1; loop_limit_i = 10'd3;
      clr_loop(); clr_ptr();
      start_capture(36);
      check("R6 no early end", 32'(first_end(36)), 30);
      check("R6 active before limit", 32'(st_a[29] != 3'd0), 1);
      check("R6 restart keeps last level", 32'(pin_a[10]), 0);
      check("R6 restart entry0", 32'(pin_a[12]), 1);
      check("R7 loop evt", 32'(loop_a[30]), 1);
      check("R7 count", 32'(loop_count_o), 3);
      clr_loop();
      check("R7 clear", 32'(loop_count_o), 0);
      cont_mode_i = 0; loop_cnt_en_i = 0;
   endtask

   task automatic t_threshold();
      for (int k = 0; k < 5; k++) put(k, k[0], 1);
      put(5, 0, 0);
      entry_limit_i = 9'd3;
      clr_ptr();
      start_capture(24);
      begin
         int c = 0;
         for (int i = 0; i < 24; i++) if (thr_a[i]) c++;
         check("R8 thr once", 32'(c), 1);
      end
      check("R8 thr time", 32'(thr_a[11]), 1);
      check("R4 end after five", 32'(first_end(24)), 17);
      entry_limit_i = 9'd128;
   endtask

   task automatic t_exhaust();
      for (int k = 0; k < DEPTH; k++) put(k, 1, 1);
      wrap_en_i = 0;
      clr_ptr();
      start_capture(30);
      check("R9 idle after last", 32'(st_a[24]), 0);
      check("R9 err set", 32'(err_a[24]), 1);
      check("R9 active before", 32'(st_a[23]), 3);
      check("R9 no end", 32'(count_end(30)), 0);
      check("R9 ptr at depth", 32'(rd_ptr_o), DEPTH);
      wrap_en_i = 1;
      clr_ptr();
      start_capture(40);
      check("R9 err cleared at start", 32'(err_a[0]), 0);
      check("R9 wrap keeps going", 32'(st_a[39] != 3'd0 && !err_a[39]), 1);
      @(negedge clk) stop_i = 1;
      @(negedge clk) stop_i = 0;
      wrap_en_i = 0;
   endtask

   task automatic t_stop();
      @(negedge clk) begin start_i = 1; stop_i = 1; end
      @(negedge clk) begin start_i = 0; stop_i = 0; end
      check("R10 stop beats start", 32'(state_o), 0);
      put(0, 1, 2); put(1, 0, 2); put(2, 0, 0);
      cont_mode_i = 1; loop_cnt_en_i = 1; loop_limit_i = 10'd0;
      idle_level_i = 0; idle_oe_i = 0;
      clr_loop(); clr_ptr();
      start_capture(60);
      check("R7 zero limit never ends", 32'(count_end(60)), 0);
      stop_i = 1;
      @(negedge clk) stop_i = 0;
      check("R10 idle after stop", 32'(state_o), 0);
      check("R10 no end on stop", 32'(end_evt_o), 0);
      check("R10 pin idle", 32'({pin_o, pin_oe_o}), 0);
      check("R7 passes counted", 32'(loop_count_o), 5);
      cont_mode_i = 0; loop_cnt_en_i = 0;
   endtask

   initial begin
      for (int k = 0; k < DEPTH; k++) tb_mem[k] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_idle_drive();
      t_one_shot();
      t_cont_loop();
      t_threshold();
      t_exhaust();
      t_stop();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule